// File: doc/BRIEF.md
# Dual-Channel DAC Code Register Bank

This block sits behind a serial word receiver and holds the digital state of a two-channel converter. Each committed 16-bit word carries a 4-bit command and a 12-bit data field. The command selects one channel or both, and it either loads a staging (input) register, moves staged values into the output registers that drive the converters, clears the outputs, latches a channel for readback, or changes the receiver's mode flags. The receiver reads these flags back: one enables the pass-through chain and one selects the shift clock edge.

The outputs can be updated in three ways. A falling edge on the active-low load pin copies both staging registers to the outputs. While that pin is held low, every accepted load goes straight through to the output. A load-and-update command always updates its channel's output. The receiver tags each commit with its cause: the bit counter reached the end of the word, the frame select rose, or the frame was aborted. Only the cause that matches the current chain mode is acted on.

Top module: `dac_regbank`

## Requirements
- R1: After reset both output codes and the readback code are 0, the staging registers hold 0, the chain-enable flag is 1 and the rising-edge flag is 0.
- R2: A word is accepted only in two cases. The first is chain enable at 1 with commit kind 2'b01 (frame select rose). The second is chain enable at 0 with commit kind 2'b00 (word count complete). Any other kind, including 2'b10 (aborted) and 2'b11, leaves all state unchanged.
- R3: The command is word bits [15:12]. The 10-bit code is word bits [11:2]. Bits [1:0] have no effect.
- R4: With the load pin high, commands 0011 (A), 0110 (B) and 1000 (both) write only the staging registers. The outputs stay unchanged.
- R5: Commands 0001 (A) and 0100 (B) write the channel's staging register and output at the same time, whatever the load pin level. The other channel is unaffected.
- R6: Command 0111 copies both staging registers to the outputs.
- R7: When the load pin is low in a cycle after a cycle in which it was high, both outputs take the staging values on the next clock.
- R8: While the load pin is low, an accepted staging load (0011, 0110, 1000) also updates the matching outputs.
- R9: Command 1011 sets both outputs to 0 and command 1100 sets both to 10'h200. The staging registers keep their values, and a clear wins over any update in the same cycle.
- R10: Commands 0010 (A) and 0101 (B) copy that channel's staging value to the readback code on the next clock.
- R11: Command 1001 clears chain enable until reset. Command 1010 sets the rising-edge flag.
- R12: Commands 0000, 1110 and 1111 change nothing.
- R13: Every effect of an accepted word or a load pin edge is visible on the clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | Committed word strobe |
| word | input | 16 | Committed word: command [15:12], data [11:0] |
| commit_kind | input | 2 | Commit cause: 00 count done, 01 frame rose, 10 aborted |
| ldac_n | input | 1 | Active-low load pin, synchronous to clk |
| dac_a | output | 10 | Channel A output code |
| dac_b | output | 10 | Channel B output code |
| rb_code | output | 10 | Readback code |
| daisy_en | output | 1 | Chain mode enable flag to receiver |
| clk_rise | output | 1 | Rising-edge shift flag to receiver |

## Verification
The staging registers cannot be seen directly. A corrupted staging value therefore shows up only when an update command, a load pin edge or a readback moves it to a port. That happens one clock after the command, and the bench issues such moves after each staging load. A wrong acceptance decision or a wrong mode flag shows up in the same cycle as a wrong output change or a missing one. The bench compares every port on every clock against a behavioural model, so a divergence is reported in the cycle it appears.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
    localparam int CODE_W = 10;
    localparam int WORD_W = 16;
    localparam int CMD_W  = 4;
    localparam int NCH    = 2;

    typedef enum logic [CMD_W-1:0] {
        OP_NOP0     = 4'b0000,
        OP_LDUP_A   = 4'b0001,
        OP_RB_A     = 4'b0010,
        OP_LD_A     = 4'b0011,
        OP_LDUP_B   = 4'b0100,
        OP_RB_B     = 4'b0101,
        OP_LD_B     = 4'b0110,
        OP_UPD_ALL  = 4'b0111,
        OP_LD_ALL   = 4'b1000,
        OP_CHAIN_OFF= 4'b1001,
        OP_EDGE_UP  = 4'b1010,
        OP_CLR_ZERO = 4'b1011,
        OP_CLR_MID  = 4'b1100,
        OP_CTRL     = 4'b1101,
        OP_RSVD     = 4'b1110,
        OP_NOP1     = 4'b1111
    } op_e;

    typedef enum logic [1:0] {
        KIND_COUNT = 2'b00,
        KIND_FRAME = 2'b01,
        KIND_ABORT = 2'b10,
        KIND_SPARE = 2'b11
    } kind_e;

    typedef struct packed {
        logic [NCH-1:0] ld;
        logic [NCH-1:0] upd;
        logic           rb;
        logic           rb_ch;
        logic           clr_zero;
        logic           clr_mid;
        logic           chain_off;
        logic           edge_up;
    } act_t;

    function automatic logic [CODE_W-1:0] mid_code();
        logic [CODE_W-1:0] m;
        m = '0;
        m[CODE_W-1] = 1'b1;
        return m;
    endfunction

    function automatic logic word_taken(input logic vld, input logic chain,
                                        input logic [1:0] kind);
        return vld && ((chain && kind == KIND_FRAME) || (!chain && kind == KIND_COUNT));
    endfunction
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_regbank_pkg::*;
(
    input  logic             take,
    input  logic [CMD_W-1:0] cmd,
    output act_t             act
);
    always_comb begin
        act = '0;
        if (take) begin
            unique case (op_e'(cmd))
                OP_LDUP_A:    begin act.ld[0] = 1'b1; act.upd[0] = 1'b1; end
                OP_LDUP_B:    begin act.ld[1] = 1'b1; act.upd[1] = 1'b1; end
                OP_LD_A:      act.ld[0] = 1'b1;
                OP_LD_B:      act.ld[1] = 1'b1;
                OP_LD_ALL:    act.ld = '1;
                OP_UPD_ALL:   act.upd = '1;
                OP_RB_A:      begin act.rb = 1'b1; act.rb_ch = 1'b0; end
                OP_RB_B:      begin act.rb = 1'b1; act.rb_ch = 1'b1; end
                OP_CLR_ZERO:  act.clr_zero = 1'b1;
                OP_CLR_MID:   act.clr_mid = 1'b1;
                OP_CHAIN_OFF: act.chain_off = 1'b1;
                OP_EDGE_UP:   act.edge_up = 1'b1;
                default:      act = '0;
            endcase
        end
    end
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg
    import dac_regbank_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         upd,
    input  logic         clr_zero,
    input  logic         clr_mid,
    input  logic [W-1:0] din,
    output logic [W-1:0] stage_q,
    output logic [W-1:0] out_q
);
    logic [W-1:0] stage_nx;
    logic [W-1:0] mid;

    always_comb begin
        stage_nx = ld ? din : stage_q;
        mid = '0;
        mid[W-1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            out_q   <= '0;
        end else begin
            stage_q <= stage_nx;
            if (clr_zero)     out_q <= '0;
            else if (clr_mid) out_q <= mid;
            else if (upd)     out_q <= stage_nx;
        end
    end
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        commit_kind,
    input  logic              ldac_n,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b,
    output logic [CODE_W-1:0] rb_code,
    output logic              daisy_en,
    output logic              clk_rise
);
    localparam int CODE_LSB = WORD_W - CMD_W - CODE_W;

    logic              take;
    act_t              act;
    logic              ldac_q;
    logic              ldac_fall;
    logic [CODE_W-1:0] code;
    logic [NCH-1:0][CODE_W-1:0] stage_q;
    logic [NCH-1:0][CODE_W-1:0] out_q;
    logic              unused_lsbs;

    assign take        = word_taken(word_vld, daisy_en, commit_kind);
    assign code        = word[WORD_W-CMD_W-1 -: CODE_W];
    assign unused_lsbs = ^word[CODE_LSB-1:0];
    assign ldac_fall   = ldac_q & ~ldac_n;

    dac_cmd_decode u_dec (
        .take (take),
        .cmd  (word[WORD_W-1 -: CMD_W]),
        .act  (act)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic upd_ch;
        assign upd_ch = act.upd[ch] | ldac_fall | (~ldac_n & act.ld[ch]);
        dac_chan_reg #(.W(CODE_W)) u_reg (
            .clk      (clk),
            .rst      (rst),
            .ld       (act.ld[ch]),
            .upd      (upd_ch),
            .clr_zero (act.clr_zero),
            .clr_mid  (act.clr_mid),
            .din      (code),
            .stage_q  (stage_q[ch]),
            .out_q    (out_q[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ldac_q   <= 1'b1;
            rb_code  <= '0;
            daisy_en <= 1'b1;
            clk_rise <= 1'b0;
        end else begin
            ldac_q <= ldac_n;
            if (act.rb)        rb_code  <= stage_q[act.rb_ch];
            if (act.chain_off) daisy_en <= 1'b0;
            if (act.edge_up)   clk_rise <= 1'b1;
        end
    end

    assign dac_a = out_q[0];
    assign dac_b = out_q[1];
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk
    import dac_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              word_vld,
    input logic [WORD_W-1:0] word,
    input logic [1:0]        commit_kind,
    input logic              ldac_n,
    input logic [CODE_W-1:0] dac_a,
    input logic [CODE_W-1:0] dac_b,
    input logic [CODE_W-1:0] rb_code,
    input logic              daisy_en,
    input logic              clk_rise
);
    logic pin_prev;
    logic ok;
    logic [CMD_W-1:0] op;

    always_ff @(posedge clk) begin
        if (rst) pin_prev <= 1'b1;
        else     pin_prev <= ldac_n;
    end

    assign ok = word_taken(word_vld, daisy_en, commit_kind);
    assign op = word[WORD_W-1 -: CMD_W];

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ok && op == 4'b1011) |=> (dac_a == '0 && dac_b == '0)); // R9
    AST_CLR_MID: assert property (@(posedge clk) disable iff (rst)
        (ok && op == 4'b1100) |=> (dac_a == mid_code() && dac_b == mid_code())); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ok && !(pin_prev && !ldac_n)) |=> ($stable(dac_a) && $stable(dac_b) && $stable(rb_code))); // R2
    AST_CHAIN_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !$rose(daisy_en)); // R11
    AST_EDGE_NO_FALL: assert property (@(posedge clk) disable iff (rst)
        !$fell(clk_rise)); // R11
    AST_LDUP_A: assert property (@(posedge clk) disable iff (rst)
        (ok && op == 4'b0001) |=> (dac_a == $past(word[WORD_W-CMD_W-1 -: CODE_W]))); // R5
    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ok && (op == 4'b0000 || op == 4'b1111) && ldac_n) |=> ($stable(dac_a) && $stable(dac_b) && $stable(daisy_en))); // R12
endmodule

bind dac_regbank dac_regbank_chk u_chk (.*);

// File: tb/tb_dac_regbank.sv
`timescale 1ns/1ps
module tb_dac_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_vld = 1'b0;
    logic [15:0] word = '0;
    logic [1:0]  commit_kind = 2'b00;
    logic        ldac_n = 1'b1;
    logic [9:0]  dac_a, dac_b, rb_code;
    logic        daisy_en, clk_rise;

    int n_run = 0;
    int n_fail = 0;
    string req = "R1";
    bit done = 0;

    always #2 clk = ~clk;

    dac_regbank dut (
        .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
        .commit_kind(commit_kind), .ldac_n(ldac_n),
        .dac_a(dac_a), .dac_b(dac_b), .rb_code(rb_code),
        .daisy_en(daisy_en), .clk_rise(clk_rise)
    );

    // behavioural model
    int m_stage[2];
    int m_out[2];
    int m_rb, m_chain, m_rise, m_pin;

    always @(posedge clk) begin
        if (rst) begin
            m_stage[0] = 0; m_stage[1] = 0; m_out[0] = 0; m_out[1] = 0;
            m_rb = 0; m_chain = 1; m_rise = 0; m_pin = 1;
        end else begin
            int c, d, ns0, ns1;
            bit take, fall, u0, u1;
            take = word_vld && ((m_chain == 1 && commit_kind == 2'b01) ||
                                (m_chain == 0 && commit_kind == 2'b00));
            fall = (m_pin == 1) && (ldac_n == 1'b0);
            c = take ? int'(word[15:12]) : 0;
            d = int'(word[11:2]);
            ns0 = m_stage[0]; ns1 = m_stage[1];
            u0 = fall; u1 = fall;
            case (c)
                1:  begin ns0 = d; u0 = 1; end
                4:  begin ns1 = d; u1 = 1; end
                3:  begin ns0 = d; if (!ldac_n) u0 = 1; end
                6:  begin ns1 = d; if (!ldac_n) u1 = 1; end
                8:  begin ns0 = d; ns1 = d; if (!ldac_n) begin u0 = 1; u1 = 1; end end
                7:  begin u0 = 1; u1 = 1; end
                2:  m_rb = m_stage[0];
                5:  m_rb = m_stage[1];
                9:  m_chain = 0;
                10: m_rise = 1;
                default: ;
            endcase
            if (c == 11)      begin m_out[0] = 0; m_out[1] = 0; end
            else if (c == 12) begin m_out[0] = 512; m_out[1] = 512; end
            else begin
                if (u0) m_out[0] = ns0;
                if (u1) m_out[1] = ns1;
            end
            m_stage[0] = ns0; m_stage[1] = ns1;
            m_pin = int'(ldac_n);
        end
    end

    task automatic cmp(string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare every clock (R13: effects appear on the following edge)
    always @(negedge clk) begin
        if (!rst && !done) begin
            cmp("dac_a", int'(dac_a), m_out[0]);
            cmp("dac_b", int'(dac_b), m_out[1]);
            cmp("rb_code", int'(rb_code), m_rb);
            cmp("daisy_en", int'(daisy_en), m_chain);
            cmp("clk_rise", int'(clk_rise), m_rise);
        end
    end

    task automatic send(input logic [3:0] c, input logic [11:0] d, input logic [1:0] k);
        @(negedge clk);
        word = {c, d}; commit_kind = k; word_vld = 1'b1;
        @(negedge clk);
        word_vld = 1'b0; word = '0;
    endtask

    task automatic expect_out(int a, int b);
        @(negedge clk);
        #0.5;
        cmp("dac_a direct", int'(dac_a), a);
        cmp("dac_b direct", int'(dac_b), b);
    endtask

    initial begin
        #400000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        req = "R1";
        cmp("reset dac_a", int'(dac_a), 0);
        cmp("reset daisy", int'(daisy_en), 1);
        cmp("reset rise", int'(clk_rise), 0);

        req = "R2";  // wrong commit kinds ignored in chain mode
        send(4'b0001, 12'h3FC, 2'b00);
        send(4'b0001, 12'h3FC, 2'b10);
        send(4'b0100, 12'h3FC, 2'b11);
        expect_out(0, 0);
        req = "R5";
        send(4'b0001, 12'h3FC, 2'b01);
        expect_out(255, 0);
        send(4'b0100, 12'hABC, 2'b01);
        expect_out(255, 12'hABC >> 2);

        req = "R3";  // low two bits ignored
        send(4'b0001, 12'h803, 2'b01);
        expect_out(512, 12'hABC >> 2);

        req = "R4";
        send(4'b0011, 12'h100, 2'b01);
        send(4'b0110, 12'h200, 2'b01);
        expect_out(512, 12'hABC >> 2);
        req = "R6";
        send(4'b0111, 12'h000, 2'b01);
        expect_out(64, 128);
        req = "R4";
        send(4'b1000, 12'hFFC, 2'b01);
        expect_out(64, 128);

        req = "R7";
        @(negedge clk); ldac_n = 1'b0;
        @(negedge clk); ldac_n = 1'b1;
        expect_out(1023, 1023);

        req = "R8";
        @(negedge clk); ldac_n = 1'b0;
        send(4'b0011, 12'h010, 2'b01);
        send(4'b0110, 12'h020, 2'b01);
        send(4'b1000, 12'h030, 2'b01);
        @(negedge clk); ldac_n = 1'b1;

        req = "R10";
        send(4'b0011, 12'h444, 2'b01);
        send(4'b0010, 12'h000, 2'b01);
        send(4'b0101, 12'h000, 2'b01);

        req = "R9";
        send(4'b1100, 12'hFFF, 2'b01);
        expect_out(512, 512);
        send(4'b1011, 12'hFFF, 2'b01);
        expect_out(0, 0);
        send(4'b0111, 12'h000, 2'b01);

        req = "R12";
        send(4'b0000, 12'hFFF, 2'b01);
        send(4'b1110, 12'h123, 2'b01);
        send(4'b1111, 12'h456, 2'b01);
        send(4'b1101, 12'h789, 2'b01);

        req = "R11";
        send(4'b1010, 12'h000, 2'b01);
        send(4'b1001, 12'h000, 2'b01);
        req = "R2";  // standalone: frame kind now ignored, count kind taken
        send(4'b0001, 12'h111, 2'b01);
        send(4'b0100, 12'h222, 2'b10);
        send(4'b0001, 12'h333, 2'b00);
        send(4'b1001, 12'h000, 2'b00);
        req = "R13";
        send(4'b0100, 12'h0F0, 2'b00);
        repeat (4) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule